// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a three-wire stereo PCM stream (bit clock, word-select and serial data) and turns it into parallel left and right samples. It runs on a fast system clock. The three serial lines are brought into that clock domain, and each rising bit-clock edge is found as a one-cycle strobe. Every half frame of the word-select line carries 32 bit slots. Each slot holds one bit, and the most significant bit comes first. The sample word inside a half frame sits at a place set by two inputs taken together: the framing select and the 2-bit word-length code.

Three framings are supported. In the first the word starts at the top of the half frame. In the second it ends at the bottom. In the third it starts one slot after the word-select edge. Word lengths of 16, 18, 20 and 24 bits are accepted. Each captured word is placed against the top of the output, so the sign bit sits in the output MSB and the unused low bits are zero. Once the right word of a frame has been captured, both outputs update together and a strobe pulses for one cycle.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is active and after it is released, before any frame completes, `left_out` and `right_out` read zero and `frame_valid` is low.
- R2: `len_code` 00, 01, 10 and 11 select word lengths L of 16, 18, 20 and 24 bits. A word shorter than the output is placed with its MSB in the output MSB, and the low bits below it are zero.
- R3: SDI and LRCLK are sampled on rising BCLK edges. Slot 0 is the first rising edge at which LRCLK differs from its value at the previous rising edge. `fmt_sel` 00 places the MSB in slot 0 and the following bits in slots 1 to L-1. Slots after the LSB are ignored.
- R4: `fmt_sel` 01 places the LSB in slot 31 and the MSB in slot 32-L. Slots before the MSB are ignored.
- R5: `fmt_sel` 10 and 11 both place the MSB in slot 1. Slot 0 and the slots after the LSB are ignored.
- R6: For `fmt_sel` 00 and 01 the left channel is the half frame with LRCLK high. For 10 and 11 it is the half with LRCLK low. The left half is sent before the right half.
- R7: `frame_valid` pulses for exactly one system clock after the last bit of a right word. `left_out` and `right_out` change only in that cycle.
- R8: A right word that has no left word captured since the previous pulse produces no pulse and leaves the outputs unchanged. No slot is counted until LRCLK has changed once after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than BCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word-select, one half frame per channel |
| sdi | input | 1 | Serial sample data, MSB first |
| fmt_sel | input | 2 | Framing: 00 top-aligned, 01 bottom-aligned, 10/11 one-slot delayed |
| len_code | input | 2 | Word length: 16, 18, 20 or 24 bits |
| left_out | output | OUT_W | Left sample, MSB-aligned |
| right_out | output | OUT_W | Right sample, MSB-aligned |
| frame_valid | output | 1 | One-cycle strobe when both samples update |

## Verification
The bench builds the receiver with 32 slots per half frame, a 24-bit output and a two-stage synchronizer chain. With these values every length code fits every framing, so all twelve combinations are reachable, including a 24-bit word that ends at slot 31 and a 24-bit delayed word that ends at slot 24. Bits outside the word are filled with random values, so a window that is off by one slot corrupts the captured sample. Changing framing between frames forces a lone half frame into the stream. That half frame exercises the rule against a right word without a left word, and the wait for the first edge after reset.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

   typedef enum logic [1:0] {
      FMT_FRONT   = 2'b00,
      FMT_REAR    = 2'b01,
      FMT_DELAY   = 2'b10,
      FMT_DELAY_B = 2'b11
   } sai_fmt_e;

   localparam int MAX_WORD = 24;

   function automatic int word_bits(input logic [1:0] code);
      case (code)
         2'b00:   return 16;
         2'b01:   return 18;
         2'b10:   return 20;
         default: return 24;
      endcase
   endfunction

   function automatic int first_slot(input sai_fmt_e f, input int wl, input int slots);
      case (f)
         FMT_FRONT: return 0;
         FMT_REAR:  return slots - wl;
         default:   return 1;
      endcase
   endfunction

   function automatic logic left_is_high(input sai_fmt_e f);
      return (f == FMT_FRONT) || (f == FMT_REAR);
   endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrclk_i,
   input  logic sdi_i,
   output logic bit_stb,
   output logic lr_bit,
   output logic sd_bit
);
   localparam int LANES = 3;

   logic [LANES-1:0] raw;
   logic [LANES-1:0] synced;
   logic             bclk_d;

   assign raw = {bclk_i, lrclk_i, sdi_i};

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [LANES-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign synced = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= synced[2];
   end

   assign bit_stb = synced[2] & ~bclk_d;
   assign lr_bit  = synced[1];
   assign sd_bit  = synced[0];
endmodule

// File: rtl/sai_rx_slot.sv
module sai_rx_slot #(
   parameter int SLOTS = 32,
   parameter int CW    = $clog2(SLOTS) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_stb,
   input  logic          lr_bit,
   output logic [CW-1:0] cur_slot,
   output logic          cur_en
);
   logic [CW-1:0] slot_q;
   logic          lr_prev;
   logic          primed;
   logic          locked;
   logic          edge_seen;

   assign edge_seen = primed && (lr_bit != lr_prev);

   always_comb begin
      if (edge_seen)                 cur_slot = '0;
      else if (slot_q == CW'(SLOTS)) cur_slot = slot_q;
      else                           cur_slot = slot_q + CW'(1);
      cur_en = bit_stb && (locked || edge_seen);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= CW'(SLOTS);
         lr_prev <= 1'b0;
         primed  <= 1'b0;
         locked  <= 1'b0;
      end else if (bit_stb) begin
         slot_q  <= cur_slot;
         lr_prev <= lr_bit;
         primed  <= 1'b1;
         if (edge_seen) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/sai_rx_capture.sv
module sai_rx_capture
   import sai_rx_pkg::*;
#(
   parameter int SLOTS = 32,
   parameter int OUT_W = 24,
   parameter int CW    = $clog2(SLOTS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic [CW-1:0]    slot,
   input  logic             lr_bit,
   input  logic             sd_bit,
   input  logic [1:0]       fmt_sel,
   input  logic [1:0]       len_code,
   output logic             word_done,
   output logic             word_left,
   output logic [OUT_W-1:0] word
);
   sai_fmt_e         fmt;
   int               wl;
   int               st;
   int               sl;
   logic             in_win;
   logic             last_bit;
   logic             is_left;
   logic [OUT_W-1:0] shreg;
   logic [OUT_W-1:0] full;

   always_comb begin
      fmt      = sai_fmt_e'(fmt_sel);
      wl       = word_bits(len_code);
      st       = first_slot(fmt, wl, SLOTS);
      sl       = int'(slot);
      in_win   = (sl >= st) && (sl < st + wl);
      last_bit = (sl == st + wl - 1);
      is_left  = left_is_high(fmt) ? lr_bit : ~lr_bit;
      full     = {shreg[OUT_W-2:0], sd_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         word      <= '0;
         word_done <= 1'b0;
         word_left <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (bit_en && in_win) begin
            shreg <= full;
            if (last_bit) begin
               word      <= full << (OUT_W - wl);
               word_done <= 1'b1;
               word_left <= is_left;
            end
         end
      end
   end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sai_rx_pkg::*;
#(
   parameter int SLOTS       = 32,
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk,
   input  logic             lrclk,
   input  logic             sdi,
   input  logic [1:0]       fmt_sel,
   input  logic [1:0]       len_code,
   output logic [OUT_W-1:0] left_out,
   output logic [OUT_W-1:0] right_out,
   output logic             frame_valid
);
   localparam int CW = $clog2(SLOTS) + 1;

   if (SLOTS < MAX_WORD + 1) begin : g_bad_slots
      $error("SLOTS too small for a delayed 24-bit word");
   end
   if (OUT_W < MAX_WORD) begin : g_bad_width
      $error("OUT_W must hold the longest word");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic             bit_stb;
   logic             lr_bit;
   logic             sd_bit;
   logic [CW-1:0]    cur_slot;
   logic             cur_en;
   logic             word_done;
   logic             word_left;
   logic [OUT_W-1:0] word;
   logic [OUT_W-1:0] left_hold;
   logic             left_pend;

   sai_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk),
      .lrclk_i (lrclk),
      .sdi_i   (sdi),
      .bit_stb (bit_stb),
      .lr_bit  (lr_bit),
      .sd_bit  (sd_bit)
   );

   sai_rx_slot #(.SLOTS(SLOTS), .CW(CW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb  (bit_stb),
      .lr_bit   (lr_bit),
      .cur_slot (cur_slot),
      .cur_en   (cur_en)
   );

   sai_rx_capture #(.SLOTS(SLOTS), .OUT_W(OUT_W), .CW(CW)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (cur_en),
      .slot      (cur_slot),
      .lr_bit    (lr_bit),
      .sd_bit    (sd_bit),
      .fmt_sel   (fmt_sel),
      .len_code  (len_code),
      .word_done (word_done),
      .word_left (word_left),
      .word      (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold   <= '0;
         left_pend   <= 1'b0;
         left_out    <= '0;
         right_out   <= '0;
         frame_valid <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         if (word_done) begin
            if (word_left) begin
               left_hold <= word;
               left_pend <= 1'b1;
            end else if (left_pend) begin
               left_out    <= left_hold;
               right_out   <= word;
               frame_valid <= 1'b1;
               left_pend   <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_valid,
   input logic [OUT_W-1:0] left_out,
   input logic [OUT_W-1:0] right_out,
   input logic             bit_stb,
   input logic             word_done,
   input logic             word_left
);
   // R7
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   // R7
   left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(left_out) |-> frame_valid);

   // R7
   right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(right_out) |-> frame_valid);

   // R6
   valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(word_done && !word_left));

   // R3
   done_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> $past(bit_stb));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_valid (frame_valid),
   .left_out    (left_out),
   .right_out   (right_out),
   .bit_stb     (bit_stb),
   .word_done   (word_done),
   .word_left   (word_left)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
   localparam int OUT_W = 24;
   localparam int SLOTS = 32;
   localparam int MAXF  = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bclk = 1'b0;
   logic             lrclk = 1'b0;
   logic             sdi = 1'b0;
   logic [1:0]       fmt_sel = 2'b00;
   logic [1:0]       len_code = 2'b00;
   logic [OUT_W-1:0] left_out;
   logic [OUT_W-1:0] right_out;
   logic             frame_valid;

   int    n_chk = 0;
   int    n_bad = 0;
   int    nexp = 0;
   int    nvalid = 0;
   logic  cur_lr = 1'b0;
   logic  finished = 1'b0;
   logic [OUT_W-1:0] exp_l [MAXF];
   logic [OUT_W-1:0] exp_r [MAXF];
   logic [OUT_W-1:0] got_l [MAXF];
   logic [OUT_W-1:0] got_r [MAXF];
   string            exp_tag [MAXF];

   always #2 clk = ~clk;

   serial_audio_rx #(.SLOTS(SLOTS), .OUT_W(OUT_W), .SYNC_STAGES(2)) u_serial_audio_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk        (bclk),
      .lrclk       (lrclk),
      .sdi         (sdi),
      .fmt_sel     (fmt_sel),
      .len_code    (len_code),
      .left_out    (left_out),
      .right_out   (right_out),
      .frame_valid (frame_valid)
   );

   always @(negedge clk) begin
      if (rst_n && frame_valid) begin
         if (nvalid < MAXF) begin
            got_l[nvalid] = left_out;
            got_r[nvalid] = right_out;
         end
         nvalid++;
      end
   end

   function automatic int wbits(input logic [1:0] c);
      case (c)
         2'b00:   return 16;
         2'b01:   return 18;
         2'b10:   return 20;
         default: return 24;
      endcase
   endfunction

   function automatic int start_of(input logic [1:0] f, input int wl);
      if (f == 2'b00) return 0;
      if (f == 2'b01) return SLOTS - wl;
      return 1;
   endfunction

   function automatic logic [OUT_W-1:0] aligned(input logic [23:0] v, input int wl);
      logic [OUT_W-1:0] m;
      m = (OUT_W'(1) << wl) - OUT_W'(1);
      return (OUT_W'(v) & m) << (OUT_W - wl);
   endfunction

   function automatic string tag_of(input logic [1:0] f);
      if (f == 2'b00) return "R3";
      if (f == 2'b01) return "R4";
      return "R5";
   endfunction

   task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic drive_bit(input logic b, input logic lr);
      @(negedge clk);
      bclk  = 1'b0;
      lrclk = lr;
      sdi   = b;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_half(input logic [23:0] v, input logic lr, input logic has_word);
      int wl = wbits(len_code);
      int st = start_of(fmt_sel, wl);
      for (int s = 0; s < SLOTS; s++) begin
         logic b;
         b = 1'($urandom);
         if (has_word && s >= st && s < st + wl) b = v[wl - 1 - (s - st)];
         drive_bit(b, lr);
      end
      cur_lr = lr;
   endtask

   task automatic send_frame(input logic [1:0] f, input logic [1:0] lc,
                             input logic [23:0] lv, input logic [23:0] rv);
      logic lhi;
      @(negedge clk);
      fmt_sel  = f;
      len_code = lc;
      lhi = (f == 2'b00) || (f == 2'b01);
      // R8: lone right-channel half when the level would not toggle
      if (cur_lr == lhi) send_half(24'h0, ~lhi, 1'b0);
      send_half(lv, lhi, 1'b1);
      send_half(rv, ~lhi, 1'b1);
      if (nexp < MAXF) begin
         exp_l[nexp]   = aligned(lv, wbits(lc));
         exp_r[nexp]   = aligned(rv, wbits(lc));
         exp_tag[nexp] = tag_of(f);
      end
      nexp++;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      // R1: outputs during reset
      check("R1", left_out, '0);
      check("R1", right_out, '0);
      check("R1", OUT_W'(frame_valid), '0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R8: a full half frame before any level change captures nothing
      cur_lr = 1'b0;
      send_half(24'hFFFFFF, 1'b1, 1'b1);
      send_half(24'hFFFFFF, 1'b0, 1'b1);
      repeat (20) @(negedge clk);
      check("R8", OUT_W'(nvalid), '0);
      check("R1", left_out, '0);

      // R2 R6: directed extremes for every framing and length
      for (int f = 0; f < 3; f++) begin
         for (int lc = 0; lc < 4; lc++) begin
            int wl = wbits(2'(lc));
            logic [23:0] pos = 24'((1 << (wl - 1)) - 1);
            logic [23:0] neg = 24'(1 << (wl - 1));
            send_frame(2'(f), 2'(lc), pos, neg);
         end
      end
      send_frame(2'b11, 2'b11, 24'h800001, 24'h7FFFFE);

      // random framing, length and data
      for (int i = 0; i < 30; i++) begin
         send_frame(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    24'($urandom), 24'($urandom));
      end

      repeat (40) @(negedge clk);
      // R7 R8: one pulse per complete frame, none for lone halves
      check("R7", OUT_W'(nvalid), OUT_W'(nexp));
      for (int i = 0; i < nexp && i < MAXF && i < nvalid; i++) begin
         // R2 R6: left and right placement
         check({exp_tag[i], "/R6 left"},  got_l[i], exp_l[i]);
         check({exp_tag[i], "/R2 right"}, got_r[i], exp_r[i]);
      end
      // R7: outputs hold after the last pulse
      check("R7", right_out, exp_r[nexp - 1]);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule